// File: doc/BRIEF.md
# Memory Write Protection Controller

This block guards the write path of a small byte-wide serial memory. It holds the status register: a protect-pin enable bit, a two-bit block-protection level, the write-enable latch and a write-in-progress flag. For every decoded write request it decides whether the request may go ahead. The command decoder supplies single-cycle strobes, the target address and the byte to write to the status register. The write timer reports through a one-cycle `cyc_done` pulse when a programming cycle ends.

Array writes are decided in the cycle after the strobe. A status register write is held pending while chip select stays low and takes effect once chip select goes high. While it is pending, the hardware protect pin can cancel it. This applies only when the enable bit is set. Once the programming cycle has started, the pin no longer affects it.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, `status` reads 0x00 and `wel`, `arr_grant`, `arr_deny`, `sr_grant` and `sr_deny` are low.
- R2: A `cmd_wren` strobe with `cs_n` low sets the write-enable latch (`wel`, `status[1]`). A `cmd_wrdi` strobe clears it. Strobes of either kind are ignored while `cs_n` is high.
- R3: An array write (`cmd_write`) made while `wel` is 0 gives an `arr_deny` pulse in the next cycle and does not start a write cycle.
- R4: `status[3:2]` selects the protected range: 00 none, 01 addresses 0x600–0x7FF, 10 addresses 0x400–0x7FF, 11 the whole array. A write into the protected range gives `arr_deny` and leaves `wel` unchanged.
- R5: A permitted array write gives an `arr_grant` pulse one cycle after the strobe and sets write-in-progress (`status[0]`). A `cyc_done` pulse while write-in-progress is set clears both write-in-progress and `wel`.
- R6: An accepted `cmd_wrsr` stays pending until `cs_n` is high. In that cycle `sr_grant` pulses, `status[7]` and `status[3:2]` take `sr_wdata[7]` and `sr_wdata[3:2]`, and write-in-progress is set.
- R7: With `status[7]` = 1 and `wp_n` low, a `cmd_wrsr` strobe gives `sr_deny` and the status register is left unchanged. With `status[7]` = 0, `wp_n` has no effect.
- R8: If `wp_n` goes low while a status write is pending and `status[7]` = 1, the write is cancelled with an `sr_deny` pulse. The register and `wel` keep their values.
- R9: Once a status write has been granted, `wp_n` going low does not alter the newly written bits or the write in progress.
- R10: While write-in-progress is set, any write strobe gives a deny pulse, and `cmd_wren` and `cmd_wrdi` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Hardware write-protect pin, low protects |
| cmd_wren | input | 1 | Set-write-enable strobe |
| cmd_wrdi | input | 1 | Clear-write-enable strobe |
| cmd_wrsr | input | 1 | Status register write strobe |
| cmd_write | input | 1 | Array write strobe |
| addr | input | 11 | Target byte address of an array write |
| sr_wdata | input | 8 | Byte offered for the status register |
| cyc_done | input | 1 | Pulse from the write timer ending a cycle |
| status | output | 8 | Status register {en,0,0,0,bp[1:0],wel,wip} |
| wel | output | 1 | Write-enable latch |
| arr_grant | output | 1 | Array write allowed |
| arr_deny | output | 1 | Array write refused |
| sr_grant | output | 1 | Status register write committed |
| sr_deny | output | 1 | Status register write refused or cancelled |

## Verification
The hardest case to reach is a status write that was accepted and is still pending, then cancelled by a falling protect pin before chip select rises. Reaching it needs the enable bit to be set first, which takes a complete granted status write and a finished timer cycle. Only after that can the latch be set again, the pin pulled low mid-transaction, and the result compared with the commit path. The stimulus walks this sequence in order. A reference model, updated on every clock, checks every output on each cycle.

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_wrsr,
  input  logic          cmd_write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] sr_wdata,
  input  logic          cyc_done,
  output logic [DW-1:0] status,
  output logic          wel,
  output logic          arr_grant,
  output logic          arr_deny,
  output logic          sr_grant,
  output logic          sr_deny
);

  logic       pin_en, wel_q, wip, pend;
  logic [1:0] bp;
  logic [2:0] pdata;

  wire act     = !cs_n;
  wire busy    = wip | pend;
  wire aw_req  = act & cmd_write;
  wire sw_req  = act & cmd_wrsr;
  wire in_prot = (bp == 2'b11) | (bp == 2'b10 & addr[AW-1]) |
                 (bp == 2'b01 & addr[AW-1] & addr[AW-2]);
  wire a_ok    = aw_req & !busy & wel_q & !in_prot;
  wire s_block = pin_en & !wp_n;
  wire s_ok    = sw_req & !busy & wel_q & !s_block;
  wire cancel  = pend & s_block;
  wire commit  = pend & !s_block & cs_n;
  wire done    = wip & cyc_done;

  wire unused_wd = ^{sr_wdata[DW-2:4], sr_wdata[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_en    <= 1'b0;
      bp        <= 2'b00;
      wel_q     <= 1'b0;
      wip       <= 1'b0;
      pend      <= 1'b0;
      pdata     <= 3'b000;
      arr_grant <= 1'b0;
      arr_deny  <= 1'b0;
      sr_grant  <= 1'b0;
      sr_deny   <= 1'b0;
    end else begin
      arr_grant <= a_ok;
      arr_deny  <= aw_req & !a_ok;
      sr_grant  <= commit;
      sr_deny   <= (sw_req & !s_ok) | cancel;

      if (s_ok) begin
        pend  <= 1'b1;
        pdata <= {sr_wdata[DW-1], sr_wdata[3:2]};
      end else if (cancel | commit) begin
        pend  <= 1'b0;
      end

      if (commit) {pin_en, bp} <= pdata;

      if (done)                wip <= 1'b0;
      else if (a_ok | commit)  wip <= 1'b1;

      if (done)                           wel_q <= 1'b0;
      else if (!busy & act & cmd_wrdi)    wel_q <= 1'b0;
      else if (!busy & act & cmd_wren)    wel_q <= 1'b1;
    end
  end

  assign wel    = wel_q;
  assign status = {pin_en, {(DW-5){1'b0}}, bp, wel_q, wip};

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> $past(wel)); // R3
  AST_NO_PROT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> !($past(status[3:2]) == 2'b11 ||
                    ($past(status[3:2]) == 2'b10 && $past(addr[AW-1])) ||
                    ($past(status[3:2]) == 2'b01 && $past(addr[AW-1]) && $past(addr[AW-2])))); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && cyc_done) |=> (!status[0] && !wel)); // R5
  AST_PIN_GATES_SR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant |-> !($past(status[7]) && !$past(wp_n))); // R8
  AST_WIP_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> !$past(status[0])); // R10
  AST_ARR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_grant, arr_deny})); // R3
  AST_SR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_grant, sr_deny})); // R6

endmodule

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, cyc_done = 0;
  logic [10:0] addr = '0;
  logic [7:0]  sr_wdata = '0;
  logic [7:0]  status;
  logic wel, arr_grant, arr_deny, sr_grant, sr_deny;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wprot_ctrl u_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_write(cmd_write), .addr(addr), .sr_wdata(sr_wdata),
    .cyc_done(cyc_done), .status(status), .wel(wel),
    .arr_grant(arr_grant), .arr_deny(arr_deny),
    .sr_grant(sr_grant), .sr_deny(sr_deny));

  // reference model
  bit m_en, m_wel, m_wip, m_pend, m_ag, m_ad, m_sg, m_sd;
  int m_bp, m_pbp;
  bit m_pen;

  function automatic bit protected_addr(int bp, int a);
    case (bp)
      1: return a >= 'h600;
      2: return a >= 'h400;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_bp = 0; m_wel = 0; m_wip = 0; m_pend = 0;
      m_ag = 0; m_ad = 0; m_sg = 0; m_sd = 0; m_pbp = 0; m_pen = 0;
    end else begin
      bit occupied, blocked, a_req, s_req, a_ok, s_ok, cxl, cmt, fin;
      occupied = m_wip || m_pend;
      blocked  = m_en && !wp_n;
      a_req = !cs_n && cmd_write;
      s_req = !cs_n && cmd_wrsr;
      a_ok  = a_req && !occupied && m_wel && !protected_addr(m_bp, int'(addr));
      s_ok  = s_req && !occupied && m_wel && !blocked;
      cxl   = m_pend && blocked;
      cmt   = m_pend && !blocked && cs_n;
      fin   = m_wip && cyc_done;
      m_ag = a_ok; m_ad = a_req && !a_ok;
      m_sg = cmt;  m_sd = (s_req && !s_ok) || cxl;
      if (cmt) begin m_en = m_pen; m_bp = m_pbp; end
      if (s_ok) begin m_pend = 1; m_pen = sr_wdata[7]; m_pbp = int'(sr_wdata[3:2]); end
      else if (cxl || cmt) m_pend = 0;
      if (fin) m_wip = 0; else if (a_ok || cmt) m_wip = 1;
      if (fin) m_wel = 0;
      else if (!occupied && !cs_n && cmd_wrdi) m_wel = 0;
      else if (!occupied && !cs_n && cmd_wren) m_wel = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    automatic int exp_st = {m_en, 3'b000, m_bp[1:0], m_wel, m_wip};
    chk(status == exp_st[7:0], "R6 status", status, exp_st);
    chk(wel == m_wel, "R2 wel", wel, m_wel);
    chk({arr_grant, arr_deny} == {m_ag, m_ad}, "R4 array result", {arr_grant, arr_deny}, {m_ag, m_ad});
    chk({sr_grant, sr_deny} == {m_sg, m_sd}, "R7 status result", {sr_grant, sr_deny}, {m_sg, m_sd});
  end

  task automatic tick; @(posedge clk); #2; endtask
  task automatic strobe(input int which);
    cs_n = 0;
    case (which)
      0: cmd_wren = 1;
      1: cmd_wrdi = 1;
      2: cmd_wrsr = 1;
      default: cmd_write = 1;
    endcase
    tick;
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0;
  endtask
  task automatic deselect; cs_n = 1; tick; endtask
  task automatic finish_cycle; cyc_done = 1; tick; cyc_done = 0; endtask
  task automatic arr_wr(input int a); addr = 11'(a); strobe(3); endtask
  task automatic sr_wr(input int d); sr_wdata = 8'(d); strobe(2); endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1; tick;
    chk(status == 8'h00, "R1 status", status, 0);
    chk({wel, arr_grant, arr_deny, sr_grant, sr_deny} == 0, "R1 outputs", wel, 0);
    // R3 write without latch
    arr_wr('h010);
    chk(arr_deny && !arr_grant, "R3 deny", arr_deny, 1);
    deselect;
    chk(status[0] == 0, "R3 no wip", status[0], 0);
    // R2 latch control, ignored while deselected
    cmd_wren = 1; tick; cmd_wren = 0;
    chk(wel == 0, "R2 deselected", wel, 0);
    strobe(0); chk(wel == 1, "R2 set", wel, 1);
    strobe(1); chk(wel == 0, "R2 clear", wel, 0);
    strobe(0); deselect;
    // R5 granted write
    arr_wr('h7FF);
    chk(arr_grant, "R5 grant", arr_grant, 1);
    chk(status[0] == 1, "R5 wip", status[0], 1);
    deselect;
    // R10 while busy
    strobe(1); chk(wel == 1, "R10 wrdi ignored", wel, 1);
    arr_wr('h001); chk(arr_deny, "R10 write denied", arr_deny, 1);
    deselect; finish_cycle;
    chk(status == 8'h00, "R5 done clears", status, 0);
    // R6 status write: enable pin, bp=10
    strobe(0); sr_wr('h88);
    chk(status == 8'h02, "R6 pending", status, 8'h02);
    deselect;
    chk(sr_grant && status == 8'h8B, "R6 commit", status, 8'h8B);
    finish_cycle;
    // R4 half protected
    strobe(0); arr_wr('h400);
    chk(arr_deny && wel, "R4 upper half deny keeps latch", {arr_deny, wel}, 3);
    deselect; arr_wr('h3FF);
    chk(arr_grant, "R4 lower half grant", arr_grant, 1);
    deselect; finish_cycle;
    // R7 pin low refuses status write
    strobe(0); wp_n = 0; sr_wr('h00);
    chk(sr_deny && status == 8'h8A, "R7 refused", status, 8'h8A);
    deselect;
    // R8 cancel while pending
    wp_n = 1; strobe(0); sr_wr('h00); tick;
    wp_n = 0; tick;
    chk(status == 8'h8A && wel, "R8 cancelled", status, 8'h8A);
    deselect; wp_n = 1;
    // R9 pin falls after commit
    strobe(0); sr_wr('h84); deselect;
    chk(sr_grant, "R9 grant", sr_grant, 1);
    wp_n = 0; tick; tick;
    chk(status == 8'h87, "R9 no effect", status, 8'h87);
    wp_n = 1; finish_cycle;
    // R4 quarter protected
    strobe(0); arr_wr('h5FF); chk(arr_grant, "R4 quarter grant", arr_grant, 1);
    deselect; finish_cycle;
    strobe(0); arr_wr('h600); chk(arr_deny, "R4 quarter deny", arr_deny, 1);
    deselect;
    // R6 all protected, pin enable off
    sr_wr('h0C); deselect; finish_cycle;
    chk(status == 8'h0C, "R6 bp all", status, 8'h0C);
    strobe(0); arr_wr('h000); chk(arr_deny, "R4 all deny", arr_deny, 1);
    deselect;
    // R7 pin ignored with enable clear
    wp_n = 0; sr_wr('h00); deselect;
    chk(sr_grant, "R7 pin ignored", sr_grant, 1);
    finish_cycle; tick;
    chk(status == 8'h00, "R7 final", status, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule